// File: doc/BRIEF.md
# Serial ADC Host Reader

This block sits on the host side of a serial successive-approximation converter. One frame of that converter takes fourteen converter clocks. The block derives the converter clock from the system clock with an integer divider. It drives the active-low start-convert line in one of three modes:

- **Single-shot:** one frame per request.
- **Free-running:** the line is held low and frames follow each other.
- **Synchronized:** the line is pulsed again at the end of every frame, so frames run back to back.

The block samples the serial data line once in the low phase of each converter clock that carries a result bit. It assembles the ten bits MSB first and publishes each finished word on a parallel bus with a one-cycle valid strobe.

The converter clock stays low while no frame is in flight, and it runs without a gap through every frame. Every sample, including the last bit, is taken on the system-clock edge nearest the middle of the converter clock's low phase. The last bit is only valid during the low phase of the final clock, so this timing is what catches it.

Top module: `adc_serial_host`

## Requirements
- R1: While reset is applied, `sc_n` is 1, `sclk` is 0, `data_vld` is 0 and `data_out` is 0.
- R2: During a frame, `sclk` is high for DIV/2 system clocks and low for DIV-DIV/2 system clocks. A frame contains exactly 14 rising edges. `sclk` stays low when no frame is in flight.
- R3: Single-shot mode is `mode` = 00. A cycle with `go` high while idle pulls `sc_n` low for exactly DIV-DIV/2 system clocks before the first rising edge of `sclk`, and `sc_n` does not change on that edge. `sc_n` returns high in the cycle after that edge. After one frame, the clock stops and `sc_n` stays high.
- R4: Free-running mode is `mode` = 01. While `go` stays high, `sc_n` stays low and a new word appears every 14*DIV system clocks.
- R5: In free-running mode, dropping `go` during a frame raises `sc_n`. That frame still completes and delivers its word, and no further frame starts.
- R6: Synchronized mode is `mode` = 10. `sc_n` rises once per frame after the frame's first rising edge. While `go` is high, `sc_n` falls in the low phase of clock 14, and the next frame starts at the following rising edge, so a word appears every 14*DIV system clocks.
- R7: Result bits are taken in the low phases of clocks 5 through 14, first bit as the MSB of `data_out`. Whatever the data line carries during clocks 1 to 4 has no effect on the word.
- R8: `data_vld` is high for exactly one system clock per word, and `data_out` holds its value until the next word completes.
- R9: `mode` = 11 behaves as single-shot. In either single-shot encoding with `go` held high, successive frames start 14*DIV + 1 + (DIV-DIV/2) system clocks apart.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| mode | input | 2 | Start-convert mode: 00 single-shot, 01 free-running, 10 synchronized, 11 single-shot |
| go | input | 1 | Conversion request: sampled when idle, and as a level to keep converting |
| sclk | output | 1 | Converter clock, 50% duty for even DIV |
| sc_n | output | 1 | Active-low start-convert to the converter |
| sdata | input | 1 | Serial data from the converter |
| data_out | output | WORD_W | Last completed word |
| data_vld | output | 1 | One-cycle strobe marking a new `data_out` |

## Verification
The bench builds the block with DIV = 6, which gives three-cycle high and low phases and a mid-low sample point one cycle clear of either converter-clock edge. At that ratio, every frame period predicted by the requirements is a small exact count: 84 system clocks back to back and 88 for repeated single shots, so the bench compares word spacing to the cycle. The converter model drives the line high during clocks 1 to 4, which makes an all-zero word expose any preamble bit leaking into the result.

// File: rtl/adc_host_pkg.sv
package adc_host_pkg;

  typedef enum logic [1:0] {
    MODE_SINGLE = 2'b00,
    MODE_FREE   = 2'b01,
    MODE_SYNC   = 2'b10,
    MODE_ALT    = 2'b11
  } conv_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'b00,
    ST_ARM   = 2'b01,
    ST_FRAME = 2'b10
  } host_state_e;

endpackage

// File: rtl/adc_clk_gen.sv
// Converter clock divider with phase and clock-number tracking.
// While idle the phase rests at DIV-1 and the clock number at the last
// clock of a frame, so starting a frame and continuing into the next one
// follow the same path.
module adc_clk_gen #(
  parameter int DIV        = 8,
  parameter int FRAME_CLKS = 14,
  localparam int HI        = DIV / 2,
  localparam int LO        = DIV - HI,
  localparam int MID       = HI + LO / 2,
  localparam int PH_W      = $clog2(DIV),
  localparam int CN_W      = $clog2(FRAME_CLKS + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            adv,
  output logic            sclk,
  output logic            active,
  output logic [CN_W-1:0] cnum,
  output logic            first_cyc,
  output logic            fall_last,
  output logic            last_cyc,
  output logic            mid_low
);

  logic [PH_W-1:0] ph_q, ph_nx;
  logic [CN_W-1:0] cn_q, cn_nx;
  logic            sclk_q, sclk_nx;
  logic            act_q;
  logic            ph_wrap;

  assign ph_wrap = (ph_q == PH_W'(DIV - 1));

  always_comb begin
    ph_nx = ph_wrap ? '0 : ph_q + 1'b1;
    cn_nx = cn_q;
    if (ph_wrap) begin
      cn_nx = (cn_q == CN_W'(FRAME_CLKS)) ? CN_W'(1) : cn_q + 1'b1;
    end
    if (!adv) begin
      ph_nx = PH_W'(DIV - 1);
      cn_nx = CN_W'(FRAME_CLKS);
    end
    sclk_nx = adv && (ph_nx < PH_W'(HI));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= PH_W'(DIV - 1);
      cn_q   <= CN_W'(FRAME_CLKS);
      sclk_q <= 1'b0;
      act_q  <= 1'b0;
    end else begin
      ph_q   <= ph_nx;
      cn_q   <= cn_nx;
      sclk_q <= sclk_nx;
      act_q  <= adv;
    end
  end

  assign sclk      = sclk_q;
  assign active    = act_q;
  assign cnum      = cn_q;
  assign first_cyc = act_q && (ph_q == '0) && (cn_q == CN_W'(1));
  assign fall_last = act_q && (ph_q == PH_W'(HI)) && (cn_q == CN_W'(FRAME_CLKS));
  assign last_cyc  = act_q && ph_wrap && (cn_q == CN_W'(FRAME_CLKS));
  assign mid_low   = act_q && (ph_q == PH_W'(MID));

endmodule

// File: rtl/adc_conv_ctrl.sv
// Start-convert sequencer shared by the three modes.
module adc_conv_ctrl
  import adc_host_pkg::*;
#(
  parameter int DIV = 8,
  localparam int LO = DIV - DIV / 2,
  localparam int AW = $clog2(LO + 1)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mode,
  input  logic       go,
  input  logic       first_cyc,
  input  logic       fall_last,
  input  logic       last_cyc,
  output logic       adv,
  output logic       sc_n
);

  host_state_e st_q, st_nx;
  logic        sc_q, sc_nx;
  logic [AW-1:0] arm_q, arm_nx;
  logic        arm_en;
  conv_mode_e  mode_e;

  assign mode_e = conv_mode_e'(mode);

  always_comb begin
    st_nx  = st_q;
    sc_nx  = sc_q;
    arm_nx = arm_q;
    arm_en = 1'b0;
    adv    = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (go) begin
          st_nx  = ST_ARM;
          sc_nx  = 1'b0;
          arm_nx = '0;
          arm_en = 1'b1;
        end
      end
      ST_ARM: begin
        if (arm_q == AW'(LO - 1)) begin
          adv   = 1'b1;
          st_nx = ST_FRAME;
        end else begin
          arm_nx = arm_q + 1'b1;
          arm_en = 1'b1;
        end
      end
      ST_FRAME: begin
        adv = !(last_cyc && sc_q);
        if (last_cyc && sc_q) begin
          st_nx = ST_IDLE;
        end
        // sc_n never moves in the cycle that precedes a rising edge
        if (!last_cyc) begin
          case (mode_e)
            MODE_FREE: sc_nx = sc_q | !go;
            MODE_SYNC: begin
              if (first_cyc) begin
                sc_nx = 1'b1;
              end else if (fall_last && go) begin
                sc_nx = 1'b0;
              end
            end
            default: begin
              if (first_cyc) begin
                sc_nx = 1'b1;
              end
            end
          endcase
        end
      end
      default: st_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE;
      sc_q <= 1'b1;
    end else begin
      st_q <= st_nx;
      sc_q <= sc_nx;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      arm_q <= '0;
    end else if (arm_en) begin
      arm_q <= arm_nx;
    end
  end

  assign sc_n = sc_q;

endmodule

// File: rtl/adc_word_asm.sv
// Serial-to-parallel word assembly, MSB first, skipping preamble clocks.
module adc_word_asm #(
  parameter int WORD_W     = 10,
  parameter int FRAME_CLKS = 14,
  parameter int CN_W       = 4,
  localparam int FIRST     = FRAME_CLKS - WORD_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mid_low,
  input  logic [CN_W-1:0]   cnum,
  input  logic              sdata,
  output logic [WORD_W-1:0] word,
  output logic              vld
);

  logic [WORD_W-1:0] sh_q, sh_nx;
  logic [WORD_W-1:0] word_q;
  logic              vld_q;
  logic              take, lsb;

  assign take  = mid_low && (cnum >= CN_W'(FIRST));
  assign lsb   = mid_low && (cnum == CN_W'(FRAME_CLKS));
  assign sh_nx = {sh_q[WORD_W-2:0], sdata};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q <= '0;
    end else if (take) begin
      sh_q <= sh_nx;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
    end else if (lsb) begin
      word_q <= sh_nx;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
    end else begin
      vld_q <= lsb;
    end
  end

  assign word = word_q;
  assign vld  = vld_q;

endmodule

// File: rtl/adc_serial_host.sv
// Host-side reader for a fourteen-clock serial converter.
module adc_serial_host #(
  parameter int DIV        = 8,
  parameter int WORD_W     = 10,
  parameter int FRAME_CLKS = 14,
  parameter int RST_STAGES = 2,
  localparam int CN_W      = $clog2(FRAME_CLKS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        mode,
  input  logic              go,
  output logic              sclk,
  output logic              sc_n,
  input  logic              sdata,
  output logic [WORD_W-1:0] data_out,
  output logic              data_vld
);

  logic [RST_STAGES-1:0] rs_q;
  logic                  rst_int_n;
  logic                  adv, clk_act;
  logic [CN_W-1:0]       cnum;
  logic                  first_cyc, fall_last, last_cyc, mid_low;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_q <= '0;
    end else begin
      rs_q <= {rs_q[RST_STAGES-2:0], 1'b1};
    end
  end
  assign rst_int_n = rs_q[RST_STAGES-1];

  adc_clk_gen #(
    .DIV        (DIV),
    .FRAME_CLKS (FRAME_CLKS)
  ) u_clk (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .adv       (adv),
    .sclk      (sclk),
    .active    (clk_act),
    .cnum      (cnum),
    .first_cyc (first_cyc),
    .fall_last (fall_last),
    .last_cyc  (last_cyc),
    .mid_low   (mid_low)
  );

  adc_conv_ctrl #(
    .DIV (DIV)
  ) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .mode      (mode),
    .go        (go),
    .first_cyc (first_cyc),
    .fall_last (fall_last),
    .last_cyc  (last_cyc),
    .adv       (adv),
    .sc_n      (sc_n)
  );

  adc_word_asm #(
    .WORD_W     (WORD_W),
    .FRAME_CLKS (FRAME_CLKS),
    .CN_W       (CN_W)
  ) u_asm (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .mid_low (mid_low),
    .cnum    (cnum),
    .sdata   (sdata),
    .word    (data_out),
    .vld     (data_vld)
  );

endmodule

// File: rtl/adc_serial_host_chk.sv
module adc_serial_host_chk #(
  parameter int WORD_W = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic [1:0]        mode,
  input logic              go,
  input logic              sclk,
  input logic              sc_n,
  input logic              active,
  input logic [WORD_W-1:0] data_out,
  input logic              data_vld
);

  // R2: converter clock only toggles inside a frame
  a_r2_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> !sclk);

  // R2: high phase lasts at least two system clocks
  a_r2_high_min: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sclk) |=> sclk);

  // R2: low phase inside a frame lasts at least two system clocks
  a_r2_low_min: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(sclk) && active) |=> !sclk);

  // R3: start-convert is steady across a rising converter edge
  a_r3_sc_setup: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sclk) |-> $stable(sc_n));

  // R3: start-convert only falls while the converter clock is low
  a_r3_sc_fall_low: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sc_n) |-> !sclk);

  // R4: in free-running mode start-convert rises only after go drops
  a_r4_free_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(sc_n) && mode == 2'b01 && $past(mode) == 2'b01) |-> !$past(go));

  // R8: one-cycle strobe
  a_r8_vld_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    data_vld |=> !data_vld);

  // R8: word held between strobes
  a_r8_word_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !data_vld |-> $stable(data_out));

endmodule

bind adc_serial_host adc_serial_host_chk #(.WORD_W(WORD_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .mode     (mode),
  .go       (go),
  .sclk     (sclk),
  .sc_n     (sc_n),
  .active   (clk_act),
  .data_out (data_out),
  .data_vld (data_vld)
);

// File: tb/adc_serial_host_tb.sv
`timescale 1ns/1ps
module adc_serial_host_tb;

  localparam int DIV    = 6;
  localparam int HI     = DIV / 2;
  localparam int LO     = DIV - HI;
  localparam int FRAME  = 14 * DIV;
  localparam int SINGLE = FRAME + 1 + LO;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] mode = 2'b00;
  logic       go = 1'b0;
  logic       sclk, sc_n;
  logic       sdata = 1'b1;
  logic [9:0] data_out;
  logic       data_vld;

  int total = 0;
  int bad = 0;
  int cyc = 0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc++;

  adc_serial_host #(.DIV(DIV)) u_dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode     (mode),
    .go       (go),
    .sclk     (sclk),
    .sc_n     (sc_n),
    .sdata    (sdata),
    .data_out (data_out),
    .data_vld (data_vld)
  );

  // ---------------- converter model ----------------
  logic [9:0] exp_q[$];
  logic [9:0] got_q[$];
  int         vt_q[$];
  int         m_cnt = 14;
  bit         m_busy = 1'b0;
  logic [9:0] m_word = '0;
  int         m_idx = 0;

  function automatic logic [9:0] pat(int k);
    case (k)
      0: return 10'h000;
      1: return 10'h201;
      2: return 10'h3FF;
      3: return 10'h2AA;
      4: return 10'h155;
      default: return 10'((k * 173 + 59) % 1024);
    endcase
  endfunction

  always @(posedge sclk) begin
    if (m_busy && m_cnt != 14) begin
      m_cnt = m_cnt + 1;
    end else if (!sc_n) begin
      m_busy = 1'b1;
      m_cnt  = 1;
      m_word = pat(m_idx);
      m_idx++;
      exp_q.push_back(m_word);
    end else begin
      m_busy = 1'b0;
    end
  end

  // preamble clocks carry ones so that leakage into the word shows
  always @(negedge sclk) begin
    #1;
    if (m_busy && m_cnt >= 5) sdata = m_word[14 - m_cnt];
    else sdata = 1'b1;
  end

  // ---------------- output monitor ----------------
  bit vld_prev = 1'b0;
  bit sc_prev = 1'b1;
  int vld_dbl = 0;
  int sc_rises = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (data_vld) begin
        got_q.push_back(data_out);
        vt_q.push_back(cyc);
        if (vld_prev) vld_dbl++;
      end
      if (sc_n && !sc_prev) sc_rises++;
    end
    vld_prev = data_vld;
    sc_prev  = sc_n;
  end

  // ---------------- helpers ----------------
  task automatic check(bit ok, string tag, int act, int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  task automatic clear_all();
    exp_q.delete();
    got_q.delete();
    vt_q.delete();
    sc_rises = 0;
    vld_dbl  = 0;
  endtask

  task automatic wait_words(int n, int limit);
    for (int i = 0; i < limit; i++) begin
      if (got_q.size() >= n) break;
      @(negedge clk);
    end
  endtask

  task automatic compare_words(string tag);
    check(got_q.size() == exp_q.size(), {tag, " word count"}, got_q.size(), exp_q.size());
    for (int i = 0; i < got_q.size(); i++) begin
      if (i < exp_q.size())
        check(got_q[i] == exp_q[i], {tag, " word value"}, int'(got_q[i]), int'(exp_q[i]));
    end
  endtask

  task automatic check_spacing(int period, string tag);
    for (int i = 1; i < vt_q.size(); i++)
      check(vt_q[i] - vt_q[i-1] == period, tag, vt_q[i] - vt_q[i-1], period);
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset();
    repeat (3) @(negedge clk);
    check(sc_n == 1'b1, "R1 sc_n in reset", sc_n, 1);
    check(sclk == 1'b0, "R1 sclk in reset", sclk, 0);
    check(data_vld == 1'b0, "R1 data_vld in reset", data_vld, 0);
    check(data_out == '0, "R1 data_out in reset", data_out, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_single();
    int  rises = 0, hi_run = 0, lo_run = 0, bad_hi = 0, bad_lo = 0;
    int  pre_lo = 0, hi_seen = 0;
    bit  seen = 1'b0, prev = 1'b0;
    logic sc_after = 1'b0;
    logic sc_at_rise = 1'b1;
    clear_all();
    mode = 2'b00;
    @(negedge clk) go = 1'b1;
    @(negedge clk) go = 1'b0;
    for (int i = 0; i < FRAME + 30; i++) begin
      if (!seen && sclk) begin
        seen = 1'b1;
        sc_at_rise = sc_n;
      end
      if (!seen && !sc_n) pre_lo++;
      if (seen) begin
        if (sclk) begin
          if (!prev) begin
            rises++;
            if (rises > 1 && lo_run != LO) bad_lo++;
            lo_run = 0;
          end
          hi_run++;
          hi_seen++;
          if (hi_seen == 2) sc_after = sc_n;
        end else begin
          if (prev) begin
            if (hi_run != HI) bad_hi++;
            hi_run = 0;
          end
          lo_run++;
        end
        prev = sclk;
      end
      @(negedge clk);
    end
    check(rises == 14, "R2 rising edges per frame", rises, 14);
    check(bad_hi == 0, "R2 high phase width", bad_hi, 0);
    check(bad_lo == 0, "R2 low phase width", bad_lo, 0);
    check(pre_lo == LO, "R3 sc_n low before first edge", pre_lo, LO);
    check(sc_at_rise == 1'b0, "R3 sc_n low at first edge", sc_at_rise, 0);
    check(sc_after == 1'b1, "R3 sc_n high after first edge", sc_after, 1);
    check(sclk == 1'b0 && sc_n == 1'b1, "R3 idle after one frame", {sclk, sc_n}, 1);
    compare_words("R7 single");
    check(vld_dbl == 0, "R8 strobe width", vld_dbl, 0);
    if (exp_q.size() > 0)
      check(data_out == exp_q[0], "R8 word held", int'(data_out), int'(exp_q[0]));
  endtask

  task automatic t_free();
    clear_all();
    mode = 2'b01;
    @(negedge clk) go = 1'b1;
    wait_words(3, 6 * FRAME);
    repeat (20) @(negedge clk);
    go = 1'b0;
    repeat (FRAME + 3 * FRAME) @(negedge clk);
    check(exp_q.size() == 4, "R5 frames after go drop", exp_q.size(), 4);
    compare_words("R4 free");
    check_spacing(FRAME, "R4 free word spacing");
    check(sc_rises == 1, "R4 sc_n held low in free mode", sc_rises, 1);
    check(sclk == 1'b0 && sc_n == 1'b1, "R5 idle after stop", {sclk, sc_n}, 1);
    check(vld_dbl == 0, "R8 strobe width free", vld_dbl, 0);
  endtask

  task automatic t_sync();
    clear_all();
    mode = 2'b10;
    @(negedge clk) go = 1'b1;
    wait_words(3, 6 * FRAME);
    repeat (20) @(negedge clk);
    go = 1'b0;
    repeat (3 * FRAME) @(negedge clk);
    check(exp_q.size() == 4, "R6 frames in sync run", exp_q.size(), 4);
    compare_words("R6 sync");
    check_spacing(FRAME, "R6 sync word spacing");
    check(sc_rises == 4, "R6 one sc_n rise per frame", sc_rises, 4);
    check(sclk == 1'b0, "R6 clock stopped", sclk, 0);
  endtask

  task automatic t_repeat(logic [1:0] m, string tag);
    clear_all();
    mode = m;
    @(negedge clk) go = 1'b1;
    wait_words(3, 6 * SINGLE);
    @(negedge clk) go = 1'b0;
    repeat (2 * SINGLE) @(negedge clk);
    compare_words(tag);
    check(vt_q.size() >= 3, {tag, " words delivered"}, vt_q.size(), 3);
    check_spacing(SINGLE, {tag, " frame spacing"});
    check(sc_rises == exp_q.size(), {tag, " sc_n pulse per frame"}, sc_rises, exp_q.size());
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset();
    t_single();
    t_single();
    t_free();
    t_sync();
    t_repeat(2'b00, "R9 single held");
    t_repeat(2'b11, "R9 mode 11");
    repeat (10) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule